// File: doc/BRIEF.md
# ADC Offset Compensation Averager

This block measures the offset of a 10-bit ADC while its input is held at half of the reference. A single start pulse begins a calibration run. The block first waits a settle interval. It then collects sixteen fresh conversions from channel 0, averages them with a 4-bit right shift and subtracts the average from the mid-scale code 512. The result is a signed compensating value. It stays on the output until a later run replaces it.

When no calibration is running, every incoming conversion is corrected and sent out on a separate stream. The correction adds the compensating value to the raw code. In battery mode, the raw code and the compensating value are each scaled by 3/2 or by 3 before they are added. The block also latches a 4-bit trim code when a run starts. A trim code of zero is replaced by the default 8.

The control is a four-state machine:
- CAL_IDLE goes to CAL_SETTLE on the *start_accept* transition (a start pulse seen in idle).
- CAL_SETTLE goes to CAL_COLLECT on *settle_over*.
- CAL_COLLECT goes to CAL_FINISH on *last_sample* (the sixteenth accepted conversion).
- CAL_FINISH goes back to CAL_IDLE on *commit*, which writes the result.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, `cal_busy_o`, `cal_done_o`, `corr_valid_o`, `comp_value_o` and `corr_data_o` are 0, and `trim_o` is 8.
- R2: A high `cal_start_i` seen in CAL_IDLE raises `cal_busy_o` from the next cycle and clears `cal_done_o`. `cal_busy_o` stays high until the run returns to CAL_IDLE.
- R3: During the SETTLE_CYCLES clock cycles that follow the start, incoming conversions are not accumulated.
- R4: Only conversions tagged with channel code 0 on `smp_chan_i` are accumulated. Conversions on other channels are dropped.
- R5: After a conversion is accepted, the next one can be accepted no earlier than GAP_CYCLES cycles later. Earlier valid conversions are dropped. The first conversion in CAL_COLLECT is accepted at once.
- R6: The sixteen accepted codes are summed in a 14-bit accumulator without overflow. Sixteen samples of 1023 give an average of 1023.
- R7: `comp_value_o` is the 11-bit signed value 512 − (sum >> 4). It and `cal_done_o` = 1 appear two cycles after the cycle in which the sixteenth conversion was accepted. Both then hold until a later run changes them.
- R8: A start pulse while `cal_busy_o` is high is ignored. The run in progress and its result are unaffected.
- R9: In CAL_IDLE, a valid conversion on any channel gives `corr_valid_o` = 1 in the next cycle, with `corr_data_o` = raw + `comp_value_o`. While busy, `corr_valid_o` stays 0.
- R10: With `bat_mode_i` = 1, the corrected value is g(raw) + g(cv). g(x) is 3x when `bat_div_i` = 1, and 3x/2 truncated toward zero when `bat_div_i` = 0.
- R11: On start_accept, `trim_o` takes `trim_code_i`, or 8 if that code is 0. It holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start_i | input | 1 | Start pulse for a calibration run |
| smp_valid_i | input | 1 | Conversion-valid strobe |
| smp_chan_i | input | CHAN_W | Channel code of the conversion |
| smp_data_i | input | DATA_W | Raw conversion code |
| bat_mode_i | input | 1 | Apply the battery gain to the corrected stream |
| bat_div_i | input | 1 | Battery gain select: 0 = 3/2, 1 = 3 |
| trim_code_i | input | TRIM_W | Trim code offered at start |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_done_o | output | 1 | Result valid since the last run |
| comp_value_o | output | DATA_W+1 | Signed compensating value |
| trim_o | output | TRIM_W | Latched trim code |
| corr_valid_o | output | 1 | Corrected-sample strobe |
| corr_data_o | output | DATA_W+4 | Signed corrected sample |

## Verification
Each output is due at a fixed number of cycles after its stimulus:
- `corr_valid_o` and `corr_data_o` appear one cycle after the idle conversion that causes them.
- `cal_busy_o` rises one cycle after the start pulse.
- The result and the done flag appear two cycles after the sixteenth accepted conversion.
- The first acceptance can happen no earlier than SETTLE_CYCLES + 1 cycles after the start.

The bench's behavioural model advances on the same rising edge as the design. All outputs are compared on the falling edge that follows, so every due cycle is checked exactly. The stimulus mixes in conversions that must be dropped: conversions during settling, other channels, samples that come too soon, and repeated start pulses. Directed checks confirm that the resulting compensating value reflects only the accepted samples.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;
    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_SETTLE  = 2'd1,
        CAL_COLLECT = 2'd2,
        CAL_FINISH  = 2'd3
    } cal_state_e;
endpackage

// File: rtl/adc_cal_ctrl.sv
`timescale 1ns/1ps
module adc_cal_ctrl
    import adc_cal_pkg::*;
#(
    parameter int CHAN_W        = 4,
    parameter int SAMPLE_LOG2   = 4,
    parameter int SETTLE_CYCLES = 200000,
    parameter int GAP_CYCLES    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [CHAN_W-1:0] chan_i,
    output cal_state_e        state_o,
    output logic              accept_o,
    output logic              clear_o,
    output logic              commit_o
);
    localparam int NUM_SAMPLES = 1 << SAMPLE_LOG2;
    localparam int SETTLE_W    = $clog2(SETTLE_CYCLES + 1);
    localparam int GAP_W       = $clog2(GAP_CYCLES + 1);
    localparam int CNT_W       = SAMPLE_LOG2 + 1;

    cal_state_e          state_q, state_d;
    logic [SETTLE_W-1:0] settle_q;
    logic [GAP_W-1:0]    gap_q;
    logic [CNT_W-1:0]    taken_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    // next state: start_accept, settle_over, last_sample, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:    if (start_i) state_d = CAL_SETTLE;
            CAL_SETTLE:  if (settle_q == '0) state_d = CAL_COLLECT;
            CAL_COLLECT: if (accept_o && taken_q == CNT_W'(NUM_SAMPLES - 1))
                             state_d = CAL_FINISH;
            CAL_FINISH:  state_d = CAL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        clear_o  = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            CAL_IDLE:    clear_o  = start_i;
            CAL_SETTLE:  ;
            CAL_COLLECT: accept_o = valid_i && (chan_i == '0) && (gap_q == '0);
            CAL_FINISH:  commit_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // settle, freshness and sample counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
            gap_q    <= '0;
            taken_q  <= '0;
        end else if (clear_o) begin
            settle_q <= SETTLE_W'(SETTLE_CYCLES - 1);
            gap_q    <= '0;
            taken_q  <= '0;
        end else if (state_q == CAL_SETTLE) begin
            if (settle_q != '0) settle_q <= settle_q - 1'b1;
        end else if (state_q == CAL_COLLECT) begin
            if (accept_o) begin
                taken_q <= taken_q + 1'b1;
                gap_q   <= GAP_W'(GAP_CYCLES - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    // checker state for the assertions below
    localparam logic [GAP_W:0] GAP_MIN = (GAP_W + 1)'(GAP_CYCLES - 1);
    logic [GAP_W:0]      since_q;
    logic                seen_q;
    logic [CNT_W-1:0]    chk_cnt_q;
    logic [SETTLE_W-1:0] settle_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q      <= '0;
            seen_q       <= 1'b0;
            chk_cnt_q    <= '0;
            settle_len_q <= '0;
        end else if (clear_o) begin
            since_q      <= '0;
            seen_q       <= 1'b0;
            chk_cnt_q    <= '0;
            settle_len_q <= '0;
        end else begin
            if (state_q == CAL_SETTLE) settle_len_q <= settle_len_q + 1'b1;
            if (accept_o) begin
                since_q   <= '0;
                seen_q    <= 1'b1;
                chk_cnt_q <= chk_cnt_q + 1'b1;
            end else if (since_q != '1) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    a_r3_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CAL_COLLECT) |-> settle_len_q == SETTLE_W'(SETTLE_CYCLES));

    a_r5_fresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && seen_q) |-> since_q >= GAP_MIN);

    a_r7_commit_after_all: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> chk_cnt_q == CNT_W'(NUM_SAMPLES));
endmodule

// File: rtl/adc_cal_accum.sv
`timescale 1ns/1ps
module adc_cal_accum #(
    parameter int DATA_W      = 10,
    parameter int SAMPLE_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     accept_i,
    input  logic                     commit_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic signed [DATA_W:0]   cv_o,
    output logic                     done_o
);
    localparam int ACC_W = DATA_W + SAMPLE_LOG2;
    localparam int CV_W  = DATA_W + 1;
    localparam logic [CV_W-1:0] MID_CODE = CV_W'(1) << (DATA_W - 1);

    logic [ACC_W-1:0]        acc_q;
    logic [DATA_W-1:0]       avg;
    logic signed [CV_W-1:0]  cv_next;
    logic signed [CV_W-1:0]  cv_q;
    logic                    done_q;

    assign avg     = acc_q[ACC_W-1:SAMPLE_LOG2];
    assign cv_next = MID_CODE - {1'b0, avg};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cv_q   <= '0;
            done_q <= 1'b0;
        end else begin
            if (clear_i) begin
                acc_q  <= '0;
                done_q <= 1'b0;
            end else if (accept_i) begin
                acc_q <= acc_q + ACC_W'(data_i);
            end
            if (commit_i) begin
                cv_q   <= cv_next;
                done_q <= 1'b1;
            end
        end
    end

    assign cv_o   = cv_q;
    assign done_o = done_q;

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> acc_q >= $past(acc_q));

    a_r7_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(cv_q));

    a_r7_done_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(commit_i));
endmodule

// File: rtl/adc_cal_correct.sv
`timescale 1ns/1ps
module adc_cal_correct #(
    parameter int DATA_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic [DATA_W-1:0]          raw_i,
    input  logic signed [DATA_W:0]     cv_i,
    input  logic                       bat_i,
    input  logic                       div_i,
    output logic                       valid_o,
    output logic signed [DATA_W+3:0]   data_o
);
    localparam int CORR_W = DATA_W + 4;
    localparam int CV_W   = DATA_W + 1;

    function automatic logic signed [CORR_W-1:0] gain(
        input logic signed [CORR_W-1:0] x, input logic b, input logic d);
        logic signed [CORR_W-1:0] t;
        t = x + (x <<< 1);
        if (!b)     return x;
        if (d)      return t;
        return (t + $signed({{(CORR_W-1){1'b0}}, t[CORR_W-1]})) >>> 1;
    endfunction

    logic signed [CORR_W-1:0] raw_s, cv_s, sum;

    assign raw_s = $signed({{(CORR_W-DATA_W){1'b0}}, raw_i});
    assign cv_s  = $signed({{(CORR_W-CV_W){cv_i[CV_W-1]}}, cv_i});
    assign sum   = gain(raw_s, bat_i, div_i) + gain(cv_s, bat_i, div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= en_i;
            if (en_i) data_o <= sum;
        end
    end
endmodule

// File: rtl/adc_offset_cal.sv
`timescale 1ns/1ps
module adc_offset_cal
    import adc_cal_pkg::*;
#(
    parameter int DATA_W        = 10,
    parameter int CHAN_W        = 4,
    parameter int SAMPLE_LOG2   = 4,
    parameter int SETTLE_CYCLES = 200000,
    parameter int GAP_CYCLES    = 12,
    parameter int TRIM_W        = 4,
    parameter int TRIM_DEFAULT  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cal_start_i,
    input  logic                      smp_valid_i,
    input  logic [CHAN_W-1:0]         smp_chan_i,
    input  logic [DATA_W-1:0]         smp_data_i,
    input  logic                      bat_mode_i,
    input  logic                      bat_div_i,
    input  logic [TRIM_W-1:0]         trim_code_i,
    output logic                      cal_busy_o,
    output logic                      cal_done_o,
    output logic signed [DATA_W:0]    comp_value_o,
    output logic [TRIM_W-1:0]         trim_o,
    output logic                      corr_valid_o,
    output logic signed [DATA_W+3:0]  corr_data_o
);
    cal_state_e        state;
    logic              accept, clear, commit;
    logic [TRIM_W-1:0] trim_q;

    adc_cal_ctrl #(
        .CHAN_W(CHAN_W), .SAMPLE_LOG2(SAMPLE_LOG2),
        .SETTLE_CYCLES(SETTLE_CYCLES), .GAP_CYCLES(GAP_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(cal_start_i),
        .valid_i(smp_valid_i), .chan_i(smp_chan_i),
        .state_o(state), .accept_o(accept), .clear_o(clear), .commit_o(commit)
    );

    adc_cal_accum #(.DATA_W(DATA_W), .SAMPLE_LOG2(SAMPLE_LOG2)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .accept_i(accept),
        .commit_i(commit), .data_i(smp_data_i),
        .cv_o(comp_value_o), .done_o(cal_done_o)
    );

    adc_cal_correct #(.DATA_W(DATA_W)) u_correct (
        .clk(clk), .rst_n(rst_n),
        .en_i(smp_valid_i && state == CAL_IDLE),
        .raw_i(smp_data_i), .cv_i(comp_value_o),
        .bat_i(bat_mode_i), .div_i(bat_div_i),
        .valid_o(corr_valid_o), .data_o(corr_data_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     trim_q <= TRIM_W'(TRIM_DEFAULT);
        else if (clear) trim_q <= (trim_code_i == '0) ? TRIM_W'(TRIM_DEFAULT) : trim_code_i;
    end

    assign trim_o     = trim_q;
    assign cal_busy_o = (state != CAL_IDLE);

    a_r9_corr_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid_o |-> $past(state == CAL_IDLE));

    a_r11_trim_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        trim_q != '0);

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy_o && cal_start_i) |=> (cal_busy_o && !cal_done_o));
endmodule

// File: tb/adc_offset_cal_tb.sv
`timescale 1ns/1ps
module adc_offset_cal_tb;
    localparam int SETTLE = 10;
    localparam int GAP    = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0, smp_valid = 1'b0, bat_mode = 1'b0, bat_div = 1'b0;
    logic [3:0]  smp_chan = '0, trim_code = '0;
    logic [9:0]  smp_data = '0;
    logic        busy, done, corr_valid;
    logic signed [10:0] comp;
    logic [3:0]  trim;
    logic signed [13:0] corr_data;

    adc_offset_cal #(.SETTLE_CYCLES(SETTLE), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start), .smp_valid_i(smp_valid),
        .smp_chan_i(smp_chan), .smp_data_i(smp_data), .bat_mode_i(bat_mode),
        .bat_div_i(bat_div), .trim_code_i(trim_code), .cal_busy_o(busy),
        .cal_done_o(done), .comp_value_o(comp), .trim_o(trim),
        .corr_valid_o(corr_valid), .corr_data_o(corr_data)
    );

    integer vectors = 0, errors = 0, cycles = 0;

    // behavioural reference model
    integer m_st = 0, m_left = 0, m_wait = 0, m_n = 0, m_sum = 0;
    integer m_cv = 0, m_done = 0, m_trim = 8, m_cov = 0, m_cd = 0;

    function automatic integer sc(input integer x, input logic b, input logic d);
        if (!b) return x;
        if (d)  return 3 * x;
        return (3 * x) / 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cv = 0; m_done = 0; m_trim = 8; m_cov = 0; m_cd = 0;
        end else begin
            m_cov = (m_st == 0 && smp_valid) ? 1 : 0;
            if (m_cov == 1) m_cd = sc(smp_data, bat_mode, bat_div) + sc(m_cv, bat_mode, bat_div);
            case (m_st)
                0: if (cal_start) begin
                       m_st = 1; m_left = SETTLE; m_done = 0; m_n = 0; m_sum = 0;
                       m_trim = (trim_code == 0) ? 8 : trim_code;
                   end
                1: begin
                       m_left = m_left - 1;
                       if (m_left == 0) begin m_st = 2; m_wait = 0; end
                   end
                2: begin
                       if (m_wait > 0) m_wait = m_wait - 1;
                       else if (smp_valid && smp_chan == 0) begin
                           m_sum = m_sum + smp_data; m_n = m_n + 1; m_wait = GAP - 1;
                           if (m_n == 16) m_st = 3;
                       end
                   end
                default: begin
                       m_cv = 512 - m_sum / 16; m_done = 1; m_st = 0;
                   end
            endcase
        end
    end

    task automatic chk(input string req, input integer act, input integer exp);
        vectors = vectors + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R8 busy", busy, (m_st != 0) ? 1 : 0);
            chk("R7 done", done, m_done);
            chk("R7 cv", comp, m_cv);
            chk("R11 trim", trim, m_trim);
            chk("R9 corr valid", corr_valid, m_cov);
            chk("R10 corr data", corr_data, m_cd);
        end
    end

    task automatic drive(input logic v, input integer ch, input integer d, input logic st);
        smp_valid = v; smp_chan = ch[3:0]; smp_data = d[9:0]; cal_start = st;
        @(negedge clk);
        smp_valid = 1'b0; cal_start = 1'b0;
    endtask

    task automatic run_cal(input integer tcode, input integer value, input string req);
        trim_code = tcode[3:0];
        drive(1'b0, 0, 0, 1'b1);
        chk("R2 busy after start", busy, 1);
        chk("R2 done cleared", done, 0);
        for (int j = 1; j <= SETTLE; j++) drive(1'b1, 0, 0, j == 3);
        chk("R8 start while busy ignored", busy, 1);
        for (int k = 0; k < 16 * GAP + 2; k++) begin
            if (k % GAP == 0)      drive(1'b1, 0, value, 1'b0);
            else if (k % GAP == 1) drive(1'b1, 0, 0, k == 5);
            else                   drive(1'b1, 5, 0, 1'b0);
        end
        drive(1'b0, 0, 0, 1'b0);
        chk({req, " R3 R4 R5 dropped samples leave cv"}, comp, 512 - value);
        chk("R7 done after run", done, 1);
        chk("R11 trim latched", trim, (tcode == 0) ? 8 : tcode);
    endtask

    task automatic corr_burst(input logic b, input logic d, input integer cv);
        bat_mode = b; bat_div = d;
        for (int i = 0; i < 5; i++) begin
            automatic integer raw = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 511 : (i == 3) ? 1023 : 600;
            drive(1'b1, i, raw, 1'b0);
            chk(b ? "R10 battery gain" : "R9 corrected sum", corr_data, sc(raw, b, d) + sc(cv, b, d));
        end
        drive(1'b0, 0, 0, 1'b0);
        chk("R9 valid drops", corr_valid, 0);
        bat_mode = 1'b0; bat_div = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 cv reset", comp, 0);
        chk("R1 trim reset", trim, 8);
        chk("R1 corr reset", corr_valid, 0);
        corr_burst(1'b0, 1'b0, 0);
        run_cal(0, 520, "R7");
        corr_burst(1'b0, 1'b0, -8);
        corr_burst(1'b1, 1'b0, -8);
        corr_burst(1'b1, 1'b1, -8);
        run_cal(5, 1023, "R6");
        corr_burst(1'b1, 1'b0, -511);
        run_cal(0, 0, "R7");
        corr_burst(1'b1, 1'b1, 512);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule